// File: doc/BRIEF.md
# Daisy-Chain Vectored Interrupt Arbiter

This block decides which of several devices gets the shared bus, and so which one the processor services next. All devices share one request line toward a bus controller. When at least one device is waiting and the bus is free, the controller raises a grant. The grant enters the chain at stage 0, the stage closest to the controller, and moves toward higher indices.

A stage that is not requesting passes the grant on to the next stage in the same cycle. The first requesting stage on the path keeps the grant, becomes the owner at the next clock edge and drives the common busy line. While it owns the bus it puts its own 8-bit vector on the data lines, so the processor can branch straight to that device's service routine. Ownership ends when the device signals that its access is done.

Priority is fixed by position in the chain. A device that keeps requesting near the controller can starve devices further down. A stage whose grant link is broken locks out every stage behind it, and this lockout is kept visible rather than hidden.

Controller states: `C_IDLE` (no grant), `C_GRANT` (grant offered while the bus is free), `C_WAIT` (bus taken, grant withdrawn). Controller transitions: `C_IDLE` to `C_GRANT` when a request is pending and busy is low. `C_GRANT` to `C_WAIT` when busy is seen. `C_GRANT` to `C_IDLE` when the request line falls. `C_WAIT` to `C_IDLE` when busy falls. Stage states: `S_IDLE` and `S_OWN`. A stage goes from `S_IDLE` to `S_OWN` when it sees the grant while requesting, and from `S_OWN` to `S_IDLE` when its done input is high.

Top module: `dci_arbiter`

## Requirements
- R1: `bus_req` is high exactly when some device has `dev_req` high and does not currently own the bus. It is combinational in the inputs.
- R2: Starting from an idle controller with the bus free, `bus_grant` rises one clock after `bus_req` rises. `bus_grant` is never high in a cycle where `bus_busy` is high.
- R3: Stage 0 is nearest the controller. The grant moves through non-requesting stages within a cycle. Among simultaneous requesters, the lowest index becomes owner one clock after the grant appears.
- R4: At most one bit of `owner` is set at any time. `bus_busy` is high exactly while some stage owns the bus.
- R5: An owner keeps ownership until its `dev_done` bit is high at a clock edge. `bus_busy` is low from that edge onward unless another stage has taken ownership.
- R6: While stage i owns the bus, `data_bus` carries bits [8*i+7 : 8*i] of the `VECTORS` parameter. With no owner, `data_bus` is zero.
- R7: After `bus_busy` falls, `bus_grant` stays low for at least the two following cycles: the controller returns to idle before it grants again.
- R8: While `link_cut[i]` is high and stage i is not requesting, no stage with an index above i can become owner, and the grant stays asserted. Once the cut clears, the waiting stage takes the bus.
- R9: A device that keeps `dev_req` high at a lower index wins every arbitration against a higher-index device that is also requesting.
- R10: After reset, `owner`, `bus_grant`, `bus_busy` and `data_bus` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| dev_req | input | N_DEV | Per-device interrupt/bus request |
| dev_done | input | N_DEV | Per-device end of access; releases ownership |
| link_cut | input | N_DEV | Per-stage broken grant link (the stage does not pass the grant on) |
| bus_req | output | 1 | Common request line toward the controller |
| bus_grant | output | 1 | Grant issued by the controller into stage 0 |
| bus_busy | output | 1 | Common busy line |
| owner | output | N_DEV | One-hot current owner |
| data_bus | output | VEC_W | Vector of the owner, zero when the bus is free |

## Verification
The bench builds the arbiter with five stages instead of the default four. Each vector is derived from the stage index, so a wrong vector select shows up as a wrong value on the data lines. Five stages leave room for a grant to pass through several idle stages before it is taken. They also allow a cut link in the middle of the chain, with requesters both in front of and behind it. A stage that keeps requesting at index 0 competes with a stage further back, which exercises starvation.

// File: rtl/dci_pkg.sv
package dci_pkg;

    typedef enum logic [1:0] {
        C_IDLE  = 2'd0,
        C_GRANT = 2'd1,
        C_WAIT  = 2'd2
    } ctrl_st_t;

    typedef enum logic {
        S_IDLE = 1'b0,
        S_OWN  = 1'b1
    } stage_st_t;

endpackage

// File: rtl/dci_ctrl.sv
module dci_ctrl
    import dci_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic req_line,
    input  logic busy_line,
    output logic grant
);

    ctrl_st_t state_q;
    ctrl_st_t state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= C_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            C_IDLE: begin
                if (req_line && !busy_line) begin
                    state_d = C_GRANT;
                end
            end
            C_GRANT: begin
                if (busy_line) begin
                    state_d = C_WAIT;
                end else if (!req_line) begin
                    state_d = C_IDLE;
                end
            end
            C_WAIT: begin
                if (!busy_line) begin
                    state_d = C_IDLE;
                end
            end
            default: state_d = C_IDLE;
        endcase
    end

    // Grant is offered only in C_GRANT and only while the bus is free.
    always_comb begin
        grant = 1'b0;
        unique case (state_q)
            C_GRANT: grant = !busy_line;
            C_IDLE,
            C_WAIT:  grant = 1'b0;
            default: grant = 1'b0;
        endcase
    end

    AST_GRANT_AFTER_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == C_IDLE && req_line && !busy_line) |=> (state_q == C_GRANT)); // R2

    AST_WAIT_THEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == C_WAIT) |=> (state_q != C_GRANT)); // R7

endmodule

// File: rtl/dci_stage.sv
module dci_stage
    import dci_pkg::*;
#(
    parameter int               VEC_W  = 8,
    parameter logic [VEC_W-1:0] VECTOR = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             grant_in,
    input  logic             req_i,
    input  logic             done_i,
    input  logic             cut_i,
    output logic             grant_out,
    output logic             pend_o,
    output logic             own_o,
    output logic [VEC_W-1:0] vec_o
);

    stage_st_t st_q;
    stage_st_t st_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= S_IDLE;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            S_IDLE: if (grant_in && req_i) st_d = S_OWN;
            S_OWN:  if (done_i)            st_d = S_IDLE;
            default: st_d = S_IDLE;
        endcase
    end

    always_comb begin
        grant_out = 1'b0;
        pend_o    = 1'b0;
        own_o     = 1'b0;
        vec_o     = '0;
        unique case (st_q)
            S_IDLE: begin
                grant_out = grant_in && !req_i && !cut_i;
                pend_o    = req_i;
            end
            S_OWN: begin
                own_o = 1'b1;
                vec_o = VECTOR;
            end
            default: ;
        endcase
    end

    AST_TAKE_ON_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(own_o) |-> $past(grant_in && req_i)); // R3

    AST_HOLD_TILL_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        (own_o && !done_i) |=> own_o); // R5

endmodule

// File: rtl/dci_vec_or.sv
module dci_vec_or #(
    parameter int N_SRC = 4,
    parameter int W     = 8
) (
    input  logic [N_SRC*W-1:0] src,
    output logic [W-1:0]       merged
);

    always_comb begin
        merged = '0;
        for (int i = 0; i < N_SRC; i++) begin
            merged = merged | src[i*W +: W];
        end
    end

endmodule

// File: rtl/dci_arbiter.sv
module dci_arbiter #(
    parameter int                     N_DEV   = 4,
    parameter int                     VEC_W   = 8,
    parameter logic [N_DEV*VEC_W-1:0] VECTORS = {8'hD3, 8'hC2, 8'hB1, 8'hA0}
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N_DEV-1:0] dev_req,
    input  logic [N_DEV-1:0] dev_done,
    input  logic [N_DEV-1:0] link_cut,
    output logic             bus_req,
    output logic             bus_grant,
    output logic             bus_busy,
    output logic [N_DEV-1:0] owner,
    output logic [VEC_W-1:0] data_bus
);

    localparam int VEC_BITS = N_DEV * VEC_W;

    logic [N_DEV:0]     chain;
    logic [N_DEV-1:0]   pend;
    logic [VEC_BITS-1:0] vec_all;

    dci_ctrl u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_line  (bus_req),
        .busy_line (bus_busy),
        .grant     (chain[0])
    );

    for (genvar g = 0; g < N_DEV; g++) begin : g_stage
        dci_stage #(
            .VEC_W  (VEC_W),
            .VECTOR (VECTORS[g*VEC_W +: VEC_W])
        ) u_stage (
            .clk       (clk),
            .rst_n     (rst_n),
            .grant_in  (chain[g]),
            .req_i     (dev_req[g]),
            .done_i    (dev_done[g]),
            .cut_i     (link_cut[g]),
            .grant_out (chain[g+1]),
            .pend_o    (pend[g]),
            .own_o     (owner[g]),
            .vec_o     (vec_all[g*VEC_W +: VEC_W])
        );
    end

    dci_vec_or #(
        .N_SRC (N_DEV),
        .W     (VEC_W)
    ) u_vec_or (
        .src    (vec_all),
        .merged (data_bus)
    );

    logic unused_tail;
    assign unused_tail = chain[N_DEV];

    assign bus_req   = |pend;
    assign bus_busy  = |owner;
    assign bus_grant = chain[0];

    AST_ONE_OWNER: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(owner)); // R4

    AST_IDLE_DATA_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_busy |-> (data_bus == '0)); // R6

endmodule

// File: tb/dci_arbiter_tb.sv
`timescale 1ns/1ps
module dci_arbiter_tb;

    localparam int N = 5;
    localparam int W = 8;

    function automatic logic [W-1:0] vec_of(input int i);
        return 8'h30 + 8'h1B * i[7:0];
    endfunction

    function automatic logic [N*W-1:0] mk_vecs();
        logic [N*W-1:0] v;
        v = '0;
        for (int i = 0; i < N; i++) v[i*W +: W] = vec_of(i);
        return v;
    endfunction

    localparam logic [N*W-1:0] VECS = mk_vecs();

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [N-1:0] dev_req = '0;
    logic [N-1:0] dev_done = '0;
    logic [N-1:0] link_cut = '0;
    logic         bus_req, bus_grant, bus_busy;
    logic [N-1:0] owner;
    logic [W-1:0] data_bus;

    int checks = 0;
    int fails = 0;
    int exp_q[$];
    bit reported = 0;

    always #2.5 clk = ~clk;

    dci_arbiter #(.N_DEV(N), .VEC_W(W), .VECTORS(VECS)) u_dut (
        .clk(clk), .rst_n(rst_n), .dev_req(dev_req), .dev_done(dev_done),
        .link_cut(link_cut), .bus_req(bus_req), .bus_grant(bus_grant),
        .bus_busy(bus_busy), .owner(owner), .data_bus(data_bus)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic report();
        if (!reported) begin
            reported = 1;
            $display("%0d/%0d checks passed", checks - fails, checks);
        end
    endtask

    function automatic int lowest(input logic [N-1:0] m);
        for (int i = 0; i < N; i++) if (m[i]) return i;
        return -1;
    endfunction

    // Monitor: each new ownership is compared against the scoreboard.
    logic busy_prev = 1'b0;
    always begin
        @(negedge clk);
        #1;
        if (rst_n && bus_busy && !busy_prev) begin
            if (exp_q.size() == 0) begin
                chk(0, "R3", "unexpected owner", owner, 0);
            end else begin
                int w;
                w = exp_q.pop_front();
                chk(owner == (N'(1) << w), "R3", "owner", owner, N'(1) << w);
                chk(data_bus == vec_of(w), "R6", "vector", data_bus, vec_of(w));
            end
        end
        if (rst_n && !bus_busy) chk(data_bus == '0, "R6", "idle data", data_bus, 0);
        busy_prev = bus_busy;
    end

    // Driver: request mask, expected winner pushed, winner released.
    task automatic serve(input logic [N-1:0] mask, input bit clear_winner);
        int w;
        w = lowest(mask);
        exp_q.push_back(w);
        @(negedge clk);
        dev_req = mask;
        for (int k = 0; k < 20 && !bus_busy; k++) begin
            @(negedge clk);
            #1;
        end
        chk(bus_busy, "R4", "busy on ownership", bus_busy, 1);
        chk(!bus_grant, "R2", "grant low while busy", bus_grant, 0);
        @(negedge clk);
        #1;
        chk(owner == (N'(1) << w), "R5", "owner holds", owner, N'(1) << w);
        @(negedge clk);
        dev_done[w] = 1'b1;
        if (clear_winner) dev_req[w] = 1'b0;
        @(negedge clk);
        dev_done = '0;
        #1;
        chk(!bus_busy, "R5", "busy released", bus_busy, 0);
        chk(!bus_grant, "R7", "no grant 1st cycle", bus_grant, 0);
        @(negedge clk);
        #1;
        chk(!bus_grant, "R7", "no grant 2nd cycle", bus_grant, 0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        chk(0, "WDOG", "watchdog expired", 0, 1);
        report();
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        #1;
        chk(owner == '0, "R10", "reset owner", owner, 0);
        chk(!bus_grant, "R10", "reset grant", bus_grant, 0);
        chk(!bus_busy, "R10", "reset busy", bus_busy, 0);
        chk(data_bus == '0, "R10", "reset data", data_bus, 0);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 / R2: request line and grant timing
        exp_q.push_back(2);
        dev_req = 5'b00100;
        #1;
        chk(bus_req, "R1", "request line", bus_req, 1);
        chk(!bus_grant, "R2", "no grant before edge", bus_grant, 0);
        @(negedge clk);
        #1;
        chk(bus_grant, "R2", "grant one cycle later", bus_grant, 1);
        chk(!bus_busy, "R2", "not yet busy", bus_busy, 0);
        @(negedge clk);
        #1;
        chk(owner == 5'b00100, "R3", "stage 2 owns", owner, 5'b00100);
        chk(!bus_req, "R1", "owner not pending", bus_req, 0);
        dev_done[2] = 1'b1;
        dev_req = '0;
        @(negedge clk);
        dev_done = '0;
        #1;
        chk(!bus_busy, "R5", "released", bus_busy, 0);
        repeat (2) @(negedge clk);

        // R3: simultaneous requests resolved by position
        serve(5'b10110, 1'b1);
        serve(dev_req, 1'b1);
        serve(dev_req, 1'b1);
        chk(exp_q.size() == 0, "R3", "all served", exp_q.size(), 0);

        // R8: broken link at stage 1 locks out stage 3
        @(negedge clk);
        link_cut = 5'b00010;
        dev_req = 5'b01000;
        repeat (8) @(negedge clk);
        #1;
        chk(owner == '0, "R8", "no owner behind cut", owner, 0);
        chk(bus_grant, "R8", "grant stays up", bus_grant, 1);
        exp_q.push_back(3);
        link_cut = '0;
        @(negedge clk);
        #1;
        chk(owner == 5'b01000, "R8", "owner after cut clears", owner, 5'b01000);
        dev_done[3] = 1'b1;
        dev_req = '0;
        @(negedge clk);
        dev_done = '0;
        repeat (2) @(negedge clk);

        // R9: continuous low-index requester starves stage 4
        for (int r = 0; r < 3; r++) serve(5'b10001, 1'b0);
        chk(owner == '0, "R9", "stage 4 never owned", owner, 0);
        @(negedge clk);
        dev_req = '0;
        repeat (4) @(negedge clk);
        // a stale ownership from the last release may be pending
        if (bus_busy) begin
            dev_done = 5'b00001;
            @(negedge clk);
            dev_done = '0;
        end
        repeat (3) @(negedge clk);
        report();
        $finish;
    end

endmodule